// File: doc/BRIEF.md
# Byte-Mapped Audio Frame Demultiplexer

The block takes one multichannel audio frame of up to 64 bytes per transfer and scatters its bytes into four independent output streams. Each input byte position has its own map entry, which names the destination stream, the channel word inside that stream (16 channel words of 32 bits each) and the byte lane inside that word. Any input byte can therefore land in any byte lane of any channel of any stream. Samples of 8, 16, 24 or 32 bits are built by mapping one to four input bytes into the lanes of one channel word.

A 64-bit byte-enable mask picks which input bytes take part. Each stream has its own enable bit. The map, the mask and the enables are loaded through a simple write-only register port. When a frame is accepted, every enabled stream presents its fully assembled frame one cycle later on its own valid/ready interface. The input stalls while any enabled stream still holds a frame that its consumer has not taken.

Top module: `byte_frame_demux`

## Requirements
- R1: After reset no stream asserts out_valid and in_ready is 1. The map, the mask and all stream enables are cleared, so an accepted frame produces no output until the stream enables are set.
- R2: Register addresses 0 to 15 hold the map. Map entry i sits in bits [8*(i%4)+7 : 8*(i%4)] of the word at address i/4. Inside an entry, bits [7:6] select the stream, bits [5:2] select the channel and bits [1:0] select the byte lane.
- R3: Address 16 holds the byte-enable bits for input bytes 0 to 31 (bit k enables byte k). Address 17 holds the enables for bytes 32 to 63 (bit k enables byte 32+k). Input byte i is in_data[8*i+7:8*i], and a byte whose enable bit is clear is dropped.
- R4: Bits [3:0] of address 18 enable streams 0 to 3. A disabled stream never raises out_valid.
- R5: Byte lane l of channel c of stream s appears at out_data bits [s*512+c*32+l*8 +: 8]. A lane that no enabled input byte targets reads as zero.
- R6: When several enabled input bytes target the same lane, the byte with the highest input index is the one delivered.
- R7: A frame is accepted on a cycle with in_valid and in_ready both high. Each stream that is enabled on that cycle raises out_valid on the next cycle. Its data is built from the map and mask in effect on the acceptance cycle, and it is all zeros if no byte targets that stream.
- R8: in_ready is low exactly when some enabled stream holds out_valid high with its out_ready low.
- R9: Once out_valid of a stream is high, it stays high, and that stream's out_data stays unchanged, until a cycle in which out_ready of that stream is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Input frame may be accepted |
| in_data | input | 512 | Input frame, byte i at bits [8i+7:8i] |
| out_valid | output | 4 | Per-stream frame valid |
| out_ready | input | 4 | Per-stream consumer ready |
| out_data | output | 2048 | Four assembled frames of 16 x 32-bit channel words |

## Verification
The bench builds the block with its default parameters: 64 input bytes, four streams and 16 channels. With these values the map entry uses all 8 of its bits, so every stream code, every channel word and both halves of the byte-enable mask can be reached, including bytes above 32 that are enabled only from the upper mask register. Directed cases cover lane collisions, disabled streams and a stalled consumer. A random phase then reprograms the map, mask and enables repeatedly while per-stream ready toggles every cycle.

// File: rtl/byte_frame_demux.sv
module byte_frame_demux #(
  parameter int NB  = 64,
  parameter int NS  = 4,
  parameter int NCH = 16,
  parameter int AW  = $clog2(NB/4 + NB/32 + 1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NB*8-1:0]       in_data,
  output logic [NS-1:0]         out_valid,
  input  logic [NS-1:0]         out_ready,
  output logic [NS*NCH*32-1:0]  out_data
);
  localparam int SW   = $clog2(NS);
  localparam int CW   = $clog2(NCH);
  localparam int EW   = SW + CW + 2;
  localparam int FW   = NCH * 32;
  localparam int MAPW = NB / 4;
  localparam int MSKW = NB / 32;
  localparam int CTRL = MAPW + MSKW;

  logic [EW-1:0]    map_q [NB];
  logic [NB-1:0]    mask_q;
  logic [NS-1:0]    en_q;
  logic [NS*FW-1:0] frame;
  logic             take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) map_q[i] <= '0;
      mask_q <= '0;
      en_q   <= '0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) < MAPW) begin
        for (int k = 0; k < 4; k++)
          map_q[int'(cfg_addr)*4 + k] <= cfg_wdata[8*k +: EW];
      end else if (int'(cfg_addr) < CTRL) begin
        mask_q[(int'(cfg_addr) - MAPW)*32 +: 32] <= cfg_wdata;
      end else if (int'(cfg_addr) == CTRL) begin
        en_q <= cfg_wdata[NS-1:0];
      end
    end
  end

  always_comb begin
    frame = '0;
    for (int i = 0; i < NB; i++)
      if (mask_q[i]) frame[{map_q[i], 3'b000} +: 8] = in_data[8*i +: 8];
  end

  assign in_ready = &(~en_q | ~out_valid | out_ready);
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (take && en_q[s]) begin
          out_valid[s]          <= 1'b1;
          out_data[s*FW +: FW]  <= frame[s*FW +: FW];
        end else if (out_ready[s]) begin
          out_valid[s] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker #(
  parameter int NS  = 4,
  parameter int NCH = 16
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NS-1:0]        out_valid,
  input logic [NS-1:0]        out_ready,
  input logic [NS*NCH*32-1:0] out_data,
  input logic [NS-1:0]        en
);
  localparam int FW = NCH * 32;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> out_valid == '0); // R1

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid & $past(~en & ~out_valid)) == '0); // R4

  AST_FIRE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid & $past(en)) == $past(en)); // R7

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & out_valid & ~out_ready) != '0) |-> !in_ready); // R8

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid & $past(out_valid & ~out_ready)) == $past(out_valid & ~out_ready)); // R9

  for (genvar s = 0; s < NS; s++) begin : g_stab
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[s] && !out_ready[s]) |=> $stable(out_data[s*FW +: FW])); // R9
  end
endmodule

bind byte_frame_demux bfd_checker #(.NS(NS), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .en(en_q)
);

// File: tb/tb_byte_frame_demux.sv
module tb_byte_frame_demux;
  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0;
  logic [4:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [511:0]  in_data = '0;
  logic [3:0]    out_valid;
  logic [3:0]    out_ready = '1;
  logic [2047:0] out_data;

  byte_frame_demux dut (.*);

  always #4 clk = ~clk;

  int    nvec = 0, nfail = 0;
  string tag = "R1";
  bit    rrand = 0;

  logic [7:0]   bmap [64];
  logic [63:0]  bmask = '0;
  logic [3:0]   ben = '0;
  bit           mv [4];
  logic [511:0] md [4];

  function automatic logic [2047:0] build(input logic [511:0] din);
    logic [2047:0] f = '0;
    for (int i = 0; i < 64; i++) begin
      if (bmask[i]) begin
        int st = int'(bmap[i][7:6]);
        int ch = int'(bmap[i][5:2]);
        int ln = int'(bmap[i][1:0]);
        f[st*512 + ch*32 + ln*8 +: 8] = din[i*8 +: 8];
      end
    end
    return f;
  endfunction

  function automatic bit exp_ready();
    bit r = 1;
    for (int s = 0; s < 4; s++)
      if (ben[s] && mv[s] && !out_ready[s]) r = 0;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) bmap[i] = '0;
    for (int s = 0; s < 4; s++) begin mv[s] = 0; md[s] = '0; end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      logic [2047:0] f;
      acc = in_valid && exp_ready();
      f = build(in_data);
      for (int s = 0; s < 4; s++) begin
        if (acc && ben[s]) begin mv[s] = 1; md[s] = f[s*512 +: 512]; end
        else if (out_ready[s]) mv[s] = 0;
      end
      if (cfg_we) begin
        if (cfg_addr < 16)
          for (int k = 0; k < 4; k++) bmap[cfg_addr*4 + k] = cfg_wdata[8*k +: 8];
        else if (cfg_addr == 16) bmask[31:0] = cfg_wdata;
        else if (cfg_addr == 17) bmask[63:32] = cfg_wdata;
        else if (cfg_addr == 18) ben = cfg_wdata[3:0];
      end
    end
  end

  always @(negedge clk) begin
    nvec++;
    if (in_ready !== exp_ready()) begin
      nfail++;
      $display("FAIL %s in_ready: got %b exp %b", tag, in_ready, exp_ready());
    end
    for (int s = 0; s < 4; s++) begin
      nvec++;
      if (out_valid[s] !== mv[s]) begin
        nfail++;
        $display("FAIL %s out_valid[%0d]: got %b exp %b", tag, s, out_valid[s], mv[s]);
      end else if (mv[s] && out_data[s*512 +: 512] !== md[s]) begin
        nfail++;
        $display("FAIL %s out_data[%0d]: got %h exp %h", tag, s, out_data[s*512 +: 512], md[s]);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rrand) out_ready = 4'($urandom);
  end

  task automatic cfg(input int a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send();
    bit acc;
    in_valid = 1;
    for (int w = 0; w < 16; w++) in_data[w*32 +: 32] = $urandom;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(8*150000);
    nfail++;
    $display("FAIL %s watchdog expired", tag);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1;
    idle(1);
    send(); send(); idle(2);
    cfg(18, 32'hF);
    send(); idle(2);

    tag = "R2/R5";
    for (int w = 0; w < 16; w++) begin
      logic [31:0] d;
      for (int k = 0; k < 4; k++) begin
        int i = w*4 + k;
        d[8*k +: 8] = {2'(i % 4), 4'(i / 4), 2'(3 - (i % 4))};
      end
      cfg(w, d);
    end
    cfg(16, 32'hFFFF_FFFF); cfg(17, 32'hFFFF_FFFF);
    repeat (3) send();
    idle(2);

    tag = "R3";
    cfg(16, 32'h0); cfg(17, 32'hFFFF_0000);
    repeat (2) send();
    cfg(16, 32'h0000_00FF); cfg(17, 32'h0);
    repeat (2) send();
    idle(2);

    tag = "R4";
    cfg(16, 32'hFFFF_FFFF); cfg(17, 32'hFFFF_FFFF);
    cfg(18, 32'h5);
    repeat (3) send();
    idle(2);

    tag = "R6";
    cfg(18, 32'hF);
    cfg(0, {8'h00, 8'h00, {2'd1, 4'd2, 2'd1}, {2'd1, 4'd2, 2'd1}});
    cfg(2, {{2'd1, 4'd2, 2'd1}, 24'h0});
    cfg(16, 32'h0000_0803); cfg(17, 32'h0);
    repeat (2) send();
    cfg(16, 32'h0000_0003);
    repeat (2) send();
    idle(2);

    tag = "R8/R9";
    cfg(16, 32'hFFFF_FFFF); cfg(17, 32'hFFFF_FFFF);
    out_ready = 4'b1101;
    send();
    fork
      send();
      begin idle(6); out_ready = 4'b1111; end
    join
    idle(2);

    tag = "R7";
    rrand = 1;
    for (int n = 0; n < 300; n++) begin
      if (n % 10 == 0) begin
        for (int w = 0; w < 16; w++) cfg(w, $urandom);
        cfg(16, $urandom); cfg(17, $urandom);
        cfg(18, $urandom);
      end
      send();
      if ($urandom % 2 == 0) idle(1);
    end
    rrand = 0;
    out_ready = '1;
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule